// File: doc/BRIEF.md
# Extended-range cascaded divider sequencer

This block sits beside a programmable down-counting divider core and stretches the core's division ratio well past what the core can hold alone. The core counts a loaded value down and raises a one-cycle terminal pulse when it expires; on that same cycle it reloads from the jam bus this block drives. A small phase counter inside the sequencer advances on every terminal pulse and decides which value appears on the jam bus for the next reload. One phase per sequence selects the user's programmed value; every other phase selects a fixed round count. The overall division ratio therefore becomes the programmed value plus a fixed number of round segments.

The programmed value arrives as packed decimal digits, four bits per digit, least significant digit in the lowest nibble. The sequencer turns them into a binary load count for the core. With the default parameters (round count 11000, nine round segments, five digits) a programmed value of 15616 gives a total ratio of 114616. Setting two round segments of 16000 instead reproduces a fixed-ratio arrangement in which a low-digit segment is followed by two scaled round segments.

The overall output pulses for one clock on the terminal pulse that closes the final segment of each sequence. After reset the first segment to run is the programmed one.

Top module: `xr_seq_divider`

## Requirements
- R1: While reset is high, the jam bus carries the binary value of the programmed digits, where the digit in nibble k (bits 4k+3..4k) has weight 10^k and nibble values 10 to 15 are weighted as they stand.
- R2: In the first cycle after reset is released, the jam bus carries the round count, because the programmed segment was loaded during reset.
- R3: Each terminal pulse advances the phase by one through REPEATS+1 phases and wraps to the programmed phase; exactly REPEATS+1 terminal pulses occur per sequence.
- R4: Outside reset, the jam bus carries the programmed digits' value only while the final round segment runs, and the round count at every other time.
- R5: The overall output is high for exactly the one cycle in which the terminal pulse closes the final segment, and low in every other cycle.
- R6: The number of cycles from one overall output pulse to the next equals the programmed value loaded for that sequence plus REPEATS times the round count.
- R7: A change of the programmed digits while the programmed or a non-final round segment runs has no effect on the jam bus or on the current sequence length.
- R8: A reset in the middle of a sequence returns the phase to the programmed segment; the first sequence after it lasts the newly loaded programmed value plus REPEATS round segments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| prog_digits_i | input | 4*NDIG | Programmed low-segment value, packed decimal digits |
| core_tc_i | input | 1 | Terminal pulse of the divider core, one cycle wide |
| core_jam_o | output | CW | Binary load count for the core's next reload |
| cycle_o | output | 1 | One-cycle pulse at the end of each full sequence |

## Verification
The awkward situations are a digit change that lands in the middle of a sequence and a reset that arrives between terminal pulses, since the programmed value is only consumed at one reload per sequence and ordinary runs never disturb it. The bench waits for an overall pulse, lets a fixed number of cycles pass so the long programmed segment is known to be running, then changes the digits and later pulses reset, while a behavioural core model keeps reloading from the jam bus. The reference predicts the jam value and the output every cycle and the period of each sequence from the digits captured at its reload.

// File: rtl/xr_seq_pkg.sv
`timescale 1ns/1ps
package xr_seq_pkg;

    // Bits per packed decimal digit on the programming input.
    localparam int unsigned DIGIT_W = 4;

    // Per-phase decode handed from the phase counter to the jam selector.
    typedef struct packed {
        logic on_prog;   // programmed segment is running
        logic on_final;  // final round segment is running
    } phase_flags_t;

    // Place value of digit position pos (10^pos).
    function automatic int unsigned dec_weight(input int unsigned pos);
        int unsigned w;
        w = 1;
        for (int unsigned k = 0; k < pos; k++) begin
            w = w * 10;
        end
        return w;
    endfunction

endpackage

// File: rtl/xr_bcd_weigh.sv
`timescale 1ns/1ps
module xr_bcd_weigh
    import xr_seq_pkg::*;
#(
    parameter int unsigned NDIG = 5,
    parameter int unsigned CW   = 18
) (
    input  logic [DIGIT_W*NDIG-1:0] digits_i,
    output logic [CW-1:0]           value_o
);

    logic [CW-1:0] partial [NDIG+1];

    assign partial[0] = '0;

    for (genvar g = 0; g < NDIG; g++) begin : g_digit
        logic [CW-1:0] nib_ext;
        logic [CW-1:0] weight;
        assign nib_ext = CW'(digits_i[DIGIT_W*g +: DIGIT_W]);
        assign weight  = CW'(dec_weight(g));
        assign partial[g+1] = partial[g] + nib_ext * weight;
    end

    assign value_o = partial[NDIG];

endmodule

// File: rtl/xr_phase_ctr.sv
`timescale 1ns/1ps
module xr_phase_ctr
    import xr_seq_pkg::*;
#(
    parameter int unsigned REPEATS = 9,
    parameter int unsigned PW      = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tc_i,
    output logic [PW-1:0] phase_o,
    output phase_flags_t  flags_o
);

    localparam logic [PW-1:0] LAST = PW'(REPEATS);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (tc_i) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end

    assign phase_o          = phase_q;
    assign flags_o.on_prog  = (phase_q == '0);
    assign flags_o.on_final = (phase_q == LAST);

endmodule

// File: rtl/xr_jam_sel.sv
`timescale 1ns/1ps
module xr_jam_sel
    import xr_seq_pkg::*;
#(
    parameter int unsigned CW          = 18,
    parameter int unsigned ROUND_COUNT = 11000
) (
    input  logic         rst,
    input  phase_flags_t flags_i,
    input  logic [CW-1:0] prog_val_i,
    output logic [CW-1:0] jam_o
);

    localparam logic [CW-1:0] ROUND_VAL = CW'(ROUND_COUNT);

    // The core reloads on the terminal pulse, so the bus always shows the
    // value of the segment that follows the running one.
    always_comb begin
        if (rst || flags_i.on_final) begin
            jam_o = prog_val_i;
        end else begin
            jam_o = ROUND_VAL;
        end
    end

endmodule

// File: rtl/xr_seq_divider.sv
`timescale 1ns/1ps
module xr_seq_divider
    import xr_seq_pkg::*;
#(
    parameter int unsigned NDIG        = 5,
    parameter int unsigned ROUND_COUNT = 11000,
    parameter int unsigned REPEATS     = 9,
    parameter int unsigned CW          = 18
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [DIGIT_W*NDIG-1:0] prog_digits_i,
    input  logic                    core_tc_i,
    output logic [CW-1:0]           core_jam_o,
    output logic                    cycle_o
);

    localparam int unsigned PW = (REPEATS < 1) ? 1 : $clog2(REPEATS + 1);

    logic [CW-1:0] prog_val;
    logic [PW-1:0] phase;
    phase_flags_t  flags;

    xr_bcd_weigh #(
        .NDIG (NDIG),
        .CW   (CW)
    ) u_weigh (
        .digits_i (prog_digits_i),
        .value_o  (prog_val)
    );

    xr_phase_ctr #(
        .REPEATS (REPEATS),
        .PW      (PW)
    ) u_phase (
        .clk     (clk),
        .rst     (rst),
        .tc_i    (core_tc_i),
        .phase_o (phase),
        .flags_o (flags)
    );

    xr_jam_sel #(
        .CW          (CW),
        .ROUND_COUNT (ROUND_COUNT)
    ) u_sel (
        .rst        (rst),
        .flags_i    (flags),
        .prog_val_i (prog_val),
        .jam_o      (core_jam_o)
    );

    assign cycle_o = core_tc_i && flags.on_final && !rst;

endmodule

// File: rtl/xr_seq_divider_chk.sv
`timescale 1ns/1ps
module xr_seq_divider_chk #(
    parameter int unsigned PW          = 4,
    parameter int unsigned CW          = 18,
    parameter int unsigned REPEATS     = 9,
    parameter int unsigned ROUND_COUNT = 11000
) (
    input logic          clk,
    input logic          rst,
    input logic          tc,
    input logic          cyc,
    input logic [CW-1:0] jam,
    input logic [PW-1:0] phase
);

    localparam logic [PW-1:0] LAST  = PW'(REPEATS);
    localparam logic [CW-1:0] ROUND = CW'(ROUND_COUNT);

    AST_CYCLE_NEEDS_TC: assert property (@(posedge clk) disable iff (rst)
        cyc |-> tc);                                                  // R5
    AST_CYCLE_AT_FINAL: assert property (@(posedge clk) disable iff (rst)
        (tc && phase == LAST) |-> cyc);                               // R5
    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (rst)
        phase <= LAST);                                               // R3
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        tc |=> (rst || phase == (($past(phase) == LAST) ? '0 : $past(phase) + 1'b1))); // R3
    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tc |=> (rst || $stable(phase)));                             // R3
    AST_ROUND_MID: assert property (@(posedge clk) disable iff (rst)
        (phase != LAST) |-> jam == ROUND);                            // R4
    AST_ROUND_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> jam == ROUND);                                 // R2
    AST_WRAP_TO_PROG: assert property (@(posedge clk) disable iff (rst)
        cyc |=> (rst || phase == '0));                                // R8

endmodule

bind xr_seq_divider xr_seq_divider_chk #(
    .PW          (PW),
    .CW          (CW),
    .REPEATS     (REPEATS),
    .ROUND_COUNT (ROUND_COUNT)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .tc    (core_tc_i),
    .cyc   (cycle_o),
    .jam   (core_jam_o),
    .phase (phase)
);

// File: tb/xr_seq_divider_bench.sv
`timescale 1ns/1ps
module xr_seq_divider_bench;

    localparam int NDIG  = 3;
    localparam int ROUND = 40;
    localparam int REP   = 3;
    localparam int CW    = 12;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [4*NDIG-1:0] dig = 12'h003;
    logic            tc;
    logic [CW-1:0]   jam;
    logic            cyc;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xr_seq_divider #(
        .NDIG (NDIG), .ROUND_COUNT (ROUND), .REPEATS (REP), .CW (CW)
    ) u_xr_seq_divider (
        .clk (clk), .rst (rst), .prog_digits_i (dig),
        .core_tc_i (tc), .core_jam_o (jam), .cycle_o (cyc)
    );

    // Behavioural divider core: reloads from the jam bus in reset and on tc.
    int core_cnt = 0;
    assign tc = (core_cnt == 1);
    always @(posedge clk) begin
        if (rst || tc) core_cnt <= int'(jam);
        else           core_cnt <= core_cnt - 1;
    end

    function automatic int digits_value(input logic [4*NDIG-1:0] d);
        int v = 0;
        int w = 1;
        for (int k = 0; k < NDIG; k++) begin
            v += int'(d[4*k +: 4]) * w;
            w *= 10;
        end
        return v;
    endfunction

    // Reference: which segment is running (0 = programmed, REP = final).
    int ref_seg = 0;
    always @(posedge clk) begin
        if (rst)     ref_seg <= 0;
        else if (tc) ref_seg <= (ref_seg == REP) ? 0 : ref_seg + 1;
    end

    task automatic check(input string tag, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    int  cyc_cnt = 0;
    int  tc_cnt = 0;
    int  loaded = 0;
    bit  prev_rst = 1'b1;
    bit  first_after = 1'b1;

    always @(negedge clk) begin
        int pv;
        int exp_jam;
        bit exp_out;
        pv = digits_value(dig);
        exp_jam = (rst || ref_seg == REP) ? pv : ROUND;
        exp_out = !rst && tc && (ref_seg == REP);
        if (rst)              check("R1 jam in reset", int'(jam), exp_jam);
        else if (prev_rst)    check("R2 jam after reset", int'(jam), exp_jam);
        else                  check("R4 jam", int'(jam), exp_jam);
        check("R5 output", int'(cyc), int'(exp_out));
        if (rst) begin
            cyc_cnt = 0;
            tc_cnt = 0;
            loaded = pv;
            first_after = 1'b1;
        end else begin
            cyc_cnt++;
            if (tc) tc_cnt++;
            if (cyc) begin
                check(first_after ? "R8 period after reset" : "R6 period",
                      cyc_cnt, loaded + REP * ROUND);
                check("R3 reloads per sequence", tc_cnt, REP + 1);
                cyc_cnt = 0;
                tc_cnt = 0;
                loaded = pv;
                first_after = 1'b0;
            end
        end
        prev_rst = rst;
    end

    task automatic wait_outs(input int n);
        int got = 0;
        while (got < n) begin
            @(negedge clk);
            if (cyc) got++;
        end
    endtask

    task automatic drive_digits(input logic [4*NDIG-1:0] v);
        @(posedge clk);
        #1 dig = v;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1;
        dig = 12'h003;                 // minimum programmed segment
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        wait_outs(3);
        drive_digits(12'h999);         // largest decimal setting
        wait_outs(3);
        drive_digits(12'hFFF);         // non-decimal nibbles, 1665
        wait_outs(2);
        // R7: digits change while the long programmed segment runs
        repeat (10) @(negedge clk);
        drive_digits(12'h123);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R7 jam unaffected by digit change", int'(jam), ROUND);
        end
        wait_outs(2);
        // R8: reset in the middle of a sequence
        repeat (30) @(posedge clk);
        #1 rst = 1'b1;
        dig = 12'h010;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        wait_outs(2);
        repeat (3) @(posedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule